// File: doc/BRIEF.md
# Underrun-Protected Unload Controller

This block runs on the receive-clock side of an elastic FIFO whose filling side may be slower than its draining side. That happens when a transmitter deliberately lowers its clock below the agreed rate on a shared time base. It also happens when the transmitter has its own clock source and that clock runs a little slow. One mechanism covers both cases. The block takes the write pointer as a Gray-coded count that is already synchronized into the read domain and converts it back to binary. It compares that count with its own read pointer and decides each cycle whether the unload pointer may step.

When draining runs ahead of filling, the next read would land on the entry the writer currently holds. In that case the controller raises a stall flag and stops reading. It starts reading again only after the occupancy has climbed back to a programmable refill level, which defaults to half the depth. This hysteresis means a slow writer produces bursts of reads with gaps between them, rather than one read every time a single word arrives.

Each read fetches the word at the current read address. That word is presented one cycle later together with a valid strobe, so downstream logic can skip the stalled cycles. A saturating counter records how many times the flow has stopped.

Top module: `unload_guard`

## Requirements
- R1: After reset, stalled is 1, out_valid is 0, rd_addr is 0, fill_level is 0 and stall_count is 0.
- R2: wr_ptr_gray carries the Gray code g = b ^ (b >> 1) of a binary write count b that is ADDR_W+1 bits wide. fill_level equals b minus the internal read count, modulo 2^(ADDR_W+1).
- R3: While not stalled, rd_advance is 1 exactly when fill_level is at least 2. A read therefore never moves the read pointer onto the writer's entry, and fill_level stays at 1 or more after any read.
- R4: While not stalled, a cycle with fill_level below 2 sets stalled on the next clock edge.
- R5: While stalled is 1 and fill_level is below RESUME, rd_advance is 0, rd_addr holds its value and out_valid is 0 in the following cycle.
- R6: While stalled is 1 and fill_level is at least RESUME (default 8, half of the 16-entry depth), rd_advance is 1 and stalled clears on the next edge. Reads after reset also wait for this level.
- R7: out_valid is 1 in the cycle after a cycle with rd_advance at 1 and is 0 otherwise. out_data then holds the mem_rdata word that was present during the advancing cycle, so words come out in write order.
- R8: stall_count rises by exactly one on each change from running to stalled, does not count the stall that follows reset, and saturates at its all-ones value.
- R9: rd_addr is the low ADDR_W bits of the read count. It rises by one, wrapping modulo the depth, on each cycle with rd_advance at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ptr_gray | input | ADDR_W+1 | Synchronized Gray-coded write count |
| mem_rdata | input | DATA_W | Word read asynchronously from the storage at rd_addr |
| rd_addr | output | ADDR_W | Storage entry being read |
| rd_advance | output | 1 | Unload pointer steps this cycle |
| out_valid | output | 1 | out_data holds a new word |
| out_data | output | DATA_W | Registered read word |
| stalled | output | 1 | Stall flag |
| fill_level | output | ADDR_W+1 | Unread words between the pointers |
| stall_count | output | CNT_W | Saturating count of stall events |

## Verification
The hardest situation to reach from the ports is saturation of the stall-event counter. It needs hundreds of separate running-to-stalled transitions, and each one requires a refill to the resume level followed by a drain down to a single word. The stimulus loops a short burst-then-idle writer pattern about three hundred times, which also wraps both pointers many times. Two other writer patterns are added: one word every third cycle, and a steady one word per cycle. With these, every cycle compares the controller against a reference model in the bench, and a scoreboard queue checks the word order.

// File: rtl/ucx_pkg.sv
package ucx_pkg;
   // Smallest occupancy at which a read keeps one word between the pointers
   localparam int unsigned MIN_SEP = 2;
endpackage

// File: rtl/ucx_gray2bin.sv
module ucx_gray2bin #(
   parameter int unsigned W = 5
) (
   input  logic [W-1:0] gray,
   output logic [W-1:0] bin
);
   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         assign bin[i] = ^gray[W-1:i];
      end
   endgenerate
endmodule

// File: rtl/ucx_sat_count.sv
module ucx_sat_count #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)                  count <= '0;
      else if (inc && count != TOP) count <= count + 1'b1;
   end
endmodule

// File: rtl/ucx_gate.sv
module ucx_gate
   import ucx_pkg::*;
#(
   parameter int unsigned PW     = 5,
   parameter int unsigned RESUME = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] wr_bin,
   output logic          advance,
   output logic          stalled,
   output logic          stall_evt,
   output logic [PW-1:0] fill,
   output logic [PW-1:0] rd_cnt
);
   localparam logic [PW-1:0] RES_L = PW'(RESUME);
   localparam logic [PW-1:0] SEP_L = PW'(MIN_SEP);

   logic          stall_q;
   logic [PW-1:0] rd_q;

   assign fill      = wr_bin - rd_q;
   assign advance   = stall_q ? (fill >= RES_L) : (fill >= SEP_L);
   assign stall_evt = !stall_q && !advance;
   assign stalled   = stall_q;
   assign rd_cnt    = rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall_q <= 1'b1;
         rd_q    <= '0;
      end else begin
         stall_q <= !advance;
         if (advance) rd_q <= rd_q + 1'b1;
      end
   end
endmodule

// File: rtl/unload_guard.sv
module unload_guard #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned RESUME = (1 << ADDR_W) / 2,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W:0]   wr_ptr_gray,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_advance,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              stalled,
   output logic [ADDR_W:0]   fill_level,
   output logic [CNT_W-1:0]  stall_count
);
   localparam int unsigned PW    = ADDR_W + 1;
   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
         $fatal(1, "ADDR_W out of range");
      end
      if (RESUME < ucx_pkg::MIN_SEP || RESUME > DEPTH) begin : g_bad_res
         $fatal(1, "RESUME must lie between 2 and the depth");
      end
      if (DATA_W < 1 || CNT_W < 1) begin : g_bad_w
         $fatal(1, "widths must be positive");
      end
   endgenerate

   logic [PW-1:0] wr_bin;
   logic [PW-1:0] rd_cnt;
   logic          evt;

   ucx_gray2bin #(.W(PW)) u_g2b (
      .gray (wr_ptr_gray),
      .bin  (wr_bin)
   );

   ucx_gate #(.PW(PW), .RESUME(RESUME)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_bin    (wr_bin),
      .advance   (rd_advance),
      .stalled   (stalled),
      .stall_evt (evt),
      .fill      (fill_level),
      .rd_cnt    (rd_cnt)
   );

   ucx_sat_count #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (evt),
      .count (stall_count)
   );

   assign rd_addr = rd_cnt[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= rd_advance;
         if (rd_advance) out_data <= mem_rdata;
      end
   end
endmodule

// File: rtl/unload_guard_chk.sv
module unload_guard_chk #(
   parameter int unsigned PW     = 5,
   parameter int unsigned RESUME = 8,
   parameter int unsigned CNT_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PW-2:0]    rd_addr,
   input logic             rd_advance,
   input logic             out_valid,
   input logic             stalled,
   input logic [PW-1:0]    fill_level,
   input logic [CNT_W-1:0] stall_count
);
   a_r3_keep_gap: assert property (@(posedge clk) disable iff (!rst_n)
      rd_advance |-> fill_level >= PW'(2));

   a_r4_set_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (!stalled && fill_level < PW'(2)) |=> stalled);

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stalled && fill_level < PW'(RESUME)) |-> !rd_advance);

   a_r6_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (stalled && fill_level >= PW'(RESUME)) |=> !stalled);

   a_r7_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
      rd_advance |=> out_valid);

   a_r7_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_advance |=> !out_valid);

   a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
      rd_advance |=> rd_addr == $past(rd_addr) + 1'b1);

   a_r9_still: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_advance |=> $stable(rd_addr));

   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stall_count == $past(stall_count)) ||
               (stall_count == $past(stall_count) + 1'b1));
endmodule

bind unload_guard unload_guard_chk #(
   .PW(ADDR_W + 1), .RESUME(RESUME), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_advance(rd_advance),
   .out_valid(out_valid), .stalled(stalled), .fill_level(fill_level),
   .stall_count(stall_count)
);

// File: tb/sim_unload_guard.sv
module sim_unload_guard;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW  = 4;
   localparam int DW  = 8;
   localparam int RES = 8;
   localparam int CW  = 8;
   localparam int PW  = AW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW:0]   wr_ptr_gray = '0;
   logic [DW-1:0] mem_rdata;
   logic [AW-1:0] rd_addr;
   logic          rd_advance, out_valid, stalled;
   logic [DW-1:0] out_data;
   logic [AW:0]   fill_level;
   logic [CW-1:0] stall_count;

   logic [DW-1:0] bmem [1 << AW];
   logic [DW-1:0] sbq [$];
   logic [PW-1:0] wcnt = '0;
   logic [DW-1:0] wval = 8'h11;

   int checks = 0, errors = 0;
   bit mon_on = 0, done = 0;

   // model state
   logic [PW-1:0] m_rd = '0;
   bit            m_stall = 1, m_valid = 0;
   int            m_cnt = 0;

   always #2.5 clk = ~clk;

   always_comb mem_rdata = bmem[rd_addr];

   unload_guard #(.ADDR_W(AW), .DATA_W(DW), .RESUME(RES), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_ptr_gray(wr_ptr_gray), .mem_rdata(mem_rdata),
      .rd_addr(rd_addr), .rd_advance(rd_advance), .out_valid(out_valid),
      .out_data(out_data), .stalled(stalled), .fill_level(fill_level),
      .stall_count(stall_count)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // driver: write one word and push it to the scoreboard
   task automatic put_word();
      @(posedge clk); #1;
      bmem[wcnt[AW-1:0]] = wval;
      sbq.push_back(wval);
      wval = wval + 8'd37;
      wcnt = wcnt + 1'b1;
      wr_ptr_gray = wcnt ^ (wcnt >> 1);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   // monitor: reference model and scoreboard, sampled at the falling edge
   always @(negedge clk) begin
      if (mon_on && !done) begin
         logic [PW-1:0] f;
         bit go;
         f  = wcnt - m_rd;
         go = m_stall ? (f >= PW'(RES)) : (f >= PW'(2));
         chk(fill_level == f, "R2 fill", fill_level, f);
         chk(stalled == m_stall, "R4/R6 stalled", stalled, m_stall);
         chk(rd_advance == go, m_stall ? "R5/R6 advance" : "R3 advance", rd_advance, go);
         chk(rd_addr == m_rd[AW-1:0], "R9 rd_addr", rd_addr, m_rd[AW-1:0]);
         chk(out_valid == m_valid, "R7 out_valid", out_valid, m_valid);
         chk(stall_count == CW'(m_cnt), "R8 stall_count", stall_count, m_cnt);
         if (out_valid) begin
            if (sbq.size() == 0) chk(0, "R7 unexpected word", out_data, -1);
            else begin
               logic [DW-1:0] e;
               e = sbq.pop_front();
               chk(out_data == e, "R7 out_data order", out_data, e);
            end
         end
         if (go) m_rd = m_rd + 1'b1;
         if (!m_stall && !go && m_cnt < (1 << CW) - 1) m_cnt++;
         m_stall = !go;
         m_valid = go;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1;
         chk(0, "watchdog", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1 << AW); i++) bmem[i] = '0;
      idle(4);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(stalled == 1'b1, "R1 stalled", stalled, 1);
      chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      chk(rd_addr == '0, "R1 rd_addr", rd_addr, 0);
      chk(fill_level == '0, "R1 fill_level", fill_level, 0);
      chk(stall_count == '0, "R1 stall_count", stall_count, 0);
      mon_on = 1;

      // R6: startup waits for RESUME, then drains to one word (R3, R4)
      for (int i = 0; i < 8; i++) put_word();
      idle(12);
      @(negedge clk);
      chk(fill_level == 1, "R3 one word kept", fill_level, 1);
      chk(stall_count == 1, "R8 first stall", stall_count, 1);

      // R5: slow writer, one word every third cycle
      for (int i = 0; i < 30; i++) begin
         put_word();
         idle(2);
      end
      idle(12);

      // R3: steady writer, reads keep pace without stalling
      for (int i = 0; i < 48; i++) put_word();
      idle(12);

      // R8: many burst rounds to drive the counter into saturation
      for (int r = 0; r < 300; r++) begin
         for (int i = 0; i < 7; i++) put_word();
         idle(12);
      end
      @(negedge clk);
      chk(stall_count == 8'hFF, "R8 saturated", stall_count, 255);
      chk(sbq.size() == 1, "R7 words drained", sbq.size(), 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule